// File: doc/BRIEF.md
# Burst Preamble Settling Monitor

This block observes the four quarter-rate output lanes of a burst-mode clock and data recovery front end. Each receive clock cycle delivers one bit per lane. Together these four bits form a group of consecutive line bits, but the lane that carries the first bit of the group is not known. At the start of each burst the transmitter sends an alternating one-zero preamble. After the split into four lanes, every lane of a settled receiver holds a constant level. Which level each lane holds depends on the random arrival phase, so it changes from burst to burst.

The monitor waits for a programmable quiet interval in which no lane toggles, and takes that interval as the gap between bursts. The first lane toggle after the gap starts the burst. The monitor then counts cycles until every lane has stayed still for a programmable run. At that point it declares the receiver settled and reports the cycle, counted from the burst start, of the last toggle it saw. Once settled, it searches the interleaved lane history for a fixed 16-bit delimiter at every possible lane rotation. On a hit it pulses a frame-start flag and reports the rotation. A lane toggle after settling that does not turn out to be the start of the delimiter is reported as an error.

Top module: `burst_settle_mon`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `locked_o`, `settled_o`, `lock_err_o` and `frame_start_o` are 0, and `rot_o` and `settle_cycles_o` are 0.
- R2: A burst can only begin after `gap_len_i` consecutive cycles without any lane toggle. These cycles are counted while waiting after reset or after a frame has been found. A quiet interval shorter than that, followed by lane activity, starts no new burst and leaves `locked_o` set.
- R3: A lane word that differs from the previous one is a toggle. Once the block is armed, the first toggle is burst cycle 0. When `stable_len_i` consecutive toggle-free cycles have followed the most recent toggle, `settled_o` pulses for one cycle, registered at the edge that samples the last of those cycles. At the same time `settle_cycles_o` takes the burst cycle number of that most recent toggle. A quiet run one cycle shorter does not settle.
- R4: `locked_o` rises together with `settled_o`. It stays high until a full quiet gap has been seen after the frame, and it falls at the edge that completes that gap.
- R5: Line bit b of the delimiter (bit b = 0 is sent first and is DELIM bit 15−b) arrives in cycle b/4 on lane ((b mod 4)+rot) mod 4. After settling, the block compares the last four lane words against DELIM = 0x83C6 for every rot in 0..3. A match pulses `frame_start_o` at the edge that samples the last delimiter word, and sets `rot_o` to the lowest matching rot.
- R6: After settling and before a frame is found, a toggle at sampled cycle t that is not followed by a delimiter match at cycles t through t+3 produces a one-cycle `lock_err_o` pulse, registered at the edge of cycle t+3. Further toggles in cycles t+1 to t+3 are absorbed into that same pulse.
- R7: After `frame_start_o`, lane toggles (payload) produce no `lock_err_o`, no `settled_o` and no further `frame_start_o`.
- R8: `rot_o` changes only at a `frame_start_o` pulse, and `settle_cycles_o` changes only at a `settled_o` pulse.
- R9: The monitor accepts either preamble phase, so a lane may settle high or low. A settled lane word of 0xA and one of 0x5 both reach lock and frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-rate receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_i | input | LANES | One bit per lane per cycle |
| gap_len_i | input | CNT_W | Quiet cycles that make up an inter-burst gap |
| stable_len_i | input | CNT_W | Quiet cycles after the last toggle that declare settling |
| locked_o | output | 1 | Settled, and no gap seen since |
| settled_o | output | 1 | One-cycle pulse when settling is declared |
| settle_cycles_o | output | CNT_W | Burst cycle of the last toggle before settling |
| lock_err_o | output | 1 | One-cycle pulse for a toggle after settling that is not the delimiter |
| frame_start_o | output | 1 | One-cycle pulse on a delimiter match |
| rot_o | output | ROT_W | Lane rotation found with the delimiter |

## Verification
The bench builds the monitor with 4 lanes, the 16-bit default delimiter and 8-bit counters. At run time it sets a gap of 10 cycles and a stable run of 6, which keeps a full burst, with its gap, preamble, delimiter and payload, to a few dozen cycles. These short values allow a burst at every one of the four rotations, with both preamble phases, together with several edge cases. Those cases are a settle count of zero, a quiet run one cycle short of settling, an injected post-lock glitch, and a pause three cycles short of a gap.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_LOCK   = 3'd3,
        ST_FRAMED = 3'd4
    } bsm_state_e;

endpackage

// File: rtl/bsm_lane_hist.sv
module bsm_lane_hist #(
    parameter int LANES = 4,
    parameter int WORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         lane_i,
    output logic                     trans_o,
    output logic [WORDS*LANES-1:0]   window_o
);

    localparam int HW = (WORDS - 1) * LANES;

    typedef struct packed {
        logic [HW-1:0] hist;
    } hist_t;

    hist_t h_d, h_q;

    always_comb begin
        h_d      = h_q;
        // newest word enters at the bottom, oldest drops off the top
        h_d.hist = HW'({h_q.hist, lane_i});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign trans_o  = |(lane_i ^ h_q.hist[LANES-1:0]);
    assign window_o = {h_q.hist, lane_i};

endmodule

// File: rtl/bsm_delim_match.sv
module bsm_delim_match #(
    parameter int                 LANES   = 4,
    parameter int                 WORDS   = 4,
    parameter int                 DELIM_W = 16,
    parameter logic [DELIM_W-1:0] DELIM   = 16'h83C6,
    parameter int                 ROT_W   = 2
) (
    input  logic [WORDS*LANES-1:0] window_i,
    output logic                   hit_o,
    output logic [ROT_W-1:0]       rot_o
);

    logic [LANES-1:0] hit_v;

    for (genvar r = 0; r < LANES; r++) begin : g_rot
        logic [DELIM_W-1:0] cand;
        for (genvar k = 0; k < WORDS; k++) begin : g_word
            for (genvar j = 0; j < LANES; j++) begin : g_bit
                // line bit k*LANES+j sits on lane (j+r) mod LANES of word k
                assign cand[DELIM_W-1-(k*LANES+j)] =
                    window_i[(WORDS-1-k)*LANES + ((j + r) % LANES)];
            end
        end
        assign hit_v[r] = (cand == DELIM);
    end

    always_comb begin
        hit_o = |hit_v;
        rot_o = '0;
        for (int r = LANES - 1; r >= 0; r--) begin
            if (hit_v[r]) rot_o = ROT_W'(r);
        end
    end

endmodule

// File: rtl/burst_settle_mon.sv
module burst_settle_mon
    import bsm_pkg::*;
#(
    parameter int                 LANES   = 4,
    parameter int                 DELIM_W = 16,
    parameter logic [DELIM_W-1:0] DELIM   = 16'h83C6,
    parameter int                 CNT_W   = 16,
    localparam int                ROT_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_i,
    input  logic [CNT_W-1:0] gap_len_i,
    input  logic [CNT_W-1:0] stable_len_i,
    output logic             locked_o,
    output logic             settled_o,
    output logic [CNT_W-1:0] settle_cycles_o,
    output logic             lock_err_o,
    output logic             frame_start_o,
    output logic [ROT_W-1:0] rot_o
);

    localparam int WORDS = DELIM_W / LANES;
    localparam int TW    = (WORDS > 2) ? $clog2(WORDS) : 1;

    typedef struct packed {
        bsm_state_e       st;
        logic [CNT_W-1:0] idle;
        logic [CNT_W-1:0] cyc;
        logic [CNT_W-1:0] last;
        logic [CNT_W-1:0] stab;
        logic [CNT_W-1:0] scnt;
        logic             pend;
        logic [TW-1:0]    tmr;
        logic [ROT_W-1:0] rot;
        logic             settled;
        logic             err;
        logic             frame;
        logic             locked;
    } regs_t;

    regs_t r_d, r_q;

    logic                   trans;
    logic [WORDS*LANES-1:0] window;
    logic                   hit;
    logic [ROT_W-1:0]       hit_rot;

    bsm_lane_hist #(.LANES(LANES), .WORDS(WORDS)) i_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_i   (lane_i),
        .trans_o  (trans),
        .window_o (window)
    );

    bsm_delim_match #(
        .LANES(LANES), .WORDS(WORDS), .DELIM_W(DELIM_W),
        .DELIM(DELIM), .ROT_W(ROT_W)
    ) i_match (
        .window_i (window),
        .hit_o    (hit),
        .rot_o    (hit_rot)
    );

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    always_comb begin
        r_d         = r_q;
        r_d.settled = 1'b0;
        r_d.err     = 1'b0;
        r_d.frame   = 1'b0;
        unique case (r_q.st)
            ST_IDLE, ST_FRAMED: begin
                // quiet-gap detection between bursts
                if (trans) begin
                    r_d.idle = '0;
                end else begin
                    r_d.idle = sat_inc(r_q.idle);
                    if (sat_inc(r_q.idle) >= gap_len_i) begin
                        r_d.st     = ST_ARMED;
                        r_d.idle   = '0;
                        r_d.locked = 1'b0;
                    end
                end
            end
            ST_ARMED: begin
                if (trans) begin
                    r_d.st   = ST_SETTLE;
                    r_d.cyc  = '0;
                    r_d.last = '0;
                    r_d.stab = '0;
                end
            end
            ST_SETTLE: begin
                r_d.cyc = sat_inc(r_q.cyc);
                if (trans) begin
                    r_d.last = sat_inc(r_q.cyc);
                    r_d.stab = '0;
                end else begin
                    r_d.stab = sat_inc(r_q.stab);
                    if (sat_inc(r_q.stab) >= stable_len_i) begin
                        r_d.st      = ST_LOCK;
                        r_d.scnt    = r_q.last;
                        r_d.settled = 1'b1;
                        r_d.locked  = 1'b1;
                        r_d.pend    = 1'b0;
                    end
                end
            end
            ST_LOCK: begin
                if (hit) begin
                    r_d.st    = ST_FRAMED;
                    r_d.rot   = hit_rot;
                    r_d.frame = 1'b1;
                    r_d.pend  = 1'b0;
                    r_d.idle  = '0;
                end else if (r_q.pend) begin
                    if (r_q.tmr == TW'(WORDS - 2)) begin
                        r_d.err  = 1'b1;
                        r_d.pend = trans;
                        r_d.tmr  = '0;
                    end else begin
                        r_d.tmr = r_q.tmr + 1'b1;
                    end
                end else if (trans) begin
                    r_d.pend = 1'b1;
                    r_d.tmr  = '0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign locked_o        = r_q.locked;
    assign settled_o       = r_q.settled;
    assign settle_cycles_o = r_q.scnt;
    assign lock_err_o      = r_q.err;
    assign frame_start_o   = r_q.frame;
    assign rot_o           = r_q.rot;

    // R1: reset clears the reported state
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!locked_o && !settled_o && !frame_start_o && !lock_err_o));

    // R4: settling always coincides with lock
    a_r4_settle_locks: assert property (@(posedge clk) disable iff (!rst_n)
        settled_o |-> locked_o);

    // R6: errors only while locked and never together with a frame
    a_r6_err_in_lock: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err_o |-> (locked_o && !frame_start_o));

    // R5: at most one event per cycle
    a_r5_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({settled_o, frame_start_o, lock_err_o}));

    // R8: rotation only moves on a frame
    a_r8_rot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (frame_start_o || $stable(rot_o)));

    // R8: settle count only moves on a settle pulse
    a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (settled_o || $stable(settle_cycles_o)));

    // R7: after a frame, no settle until a gap has dropped lock
    a_r7_no_resettle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |=> !settled_o);

endmodule

// File: tb/test_burst_settle_mon.sv
`timescale 1ns/1ps
module test_burst_settle_mon;

    localparam int            CNT_W = 8;
    localparam int            GAP   = 10;
    localparam int            STAB  = 6;
    localparam int            PRE_N = 30;
    localparam logic [15:0]   EXP_DELIM = 16'h83C6;

    typedef struct {
        int kind;   // 0 settle, 1 frame, 2 error
        int val;
        int cyc;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       lane = '0;
    logic [CNT_W-1:0] gap_len = CNT_W'(GAP);
    logic [CNT_W-1:0] stable_len = CNT_W'(STAB);
    logic             locked_o, settled_o, lock_err_o, frame_start_o;
    logic [CNT_W-1:0] settle_cycles_o;
    logic [1:0]       rot_o;

    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    bit   mon_on = 1'b0;
    bit   done   = 1'b0;
    exp_t sb[$];
    logic [3:0] noise_q[$];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    burst_settle_mon #(.CNT_W(CNT_W)) i_burst_settle_mon (
        .clk             (clk),
        .rst_n           (rst_n),
        .lane_i          (lane),
        .gap_len_i       (gap_len),
        .stable_len_i    (stable_len),
        .locked_o        (locked_o),
        .settled_o       (settled_o),
        .settle_cycles_o (settle_cycles_o),
        .lock_err_o      (lock_err_o),
        .frame_start_o   (frame_start_o),
        .rot_o           (rot_o)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic string kind_tag(input int k);
        return (k == 0) ? "R3 settle" : (k == 1) ? "R5 frame" : "R6 error";
    endfunction

    task automatic take(input int kind, input int val);
        exp_t e;
        checks++;
        if (sb.size() == 0) begin
            fails++;
            $display("FAIL R7 unexpected %s event value %0d expected none",
                     kind_tag(kind), val);
        end else begin
            e = sb.pop_front();
            if (e.kind != kind || e.val != val || e.cyc != cyc) begin
                fails++;
                $display("FAIL %s got kind %0d val %0d cyc %0d expected kind %0d val %0d cyc %0d",
                         kind_tag(e.kind), kind, val, cyc, e.kind, e.val, e.cyc);
            end
        end
    endtask

    // monitor: pops the scoreboard as events appear
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (settled_o)     take(0, int'(settle_cycles_o));
                if (frame_start_o) take(1, int'(rot_o));
                if (lock_err_o)    take(2, 0);
            end
        end
    end

    task automatic drive_gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lane = 4'h0;
        end
    endtask

    task automatic drive_payload(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lane = 4'(i) ^ 4'h6;
        end
    endtask

    // one burst: noise_q, preamble, delimiter, payload; expectations pushed first
    task automatic run_burst(input int rot, input int ph, input bit glitch);
        logic [3:0] seq[$];
        logic [3:0] pre, prev, w;
        int last, sidx, sval, gidx, dpos, base;
        for (int l = 0; l < 4; l++) pre[l] = ((((l - rot + 4) % 4) % 2) == ph);
        seq = noise_q;
        for (int i = 0; i < PRE_N; i++) seq.push_back(pre);
        // R3 model: first index with STAB quiet cycles after the last toggle
        prev = 4'h0; last = -1; sidx = -1; sval = 0;
        for (int i = 0; i < seq.size(); i++) begin
            if (seq[i] != prev) last = i;
            else if (last >= 0 && sidx < 0 && (i - last) == STAB) begin
                sidx = i;
                sval = last;
            end
            prev = seq[i];
        end
        gidx = sidx + 2;
        if (glitch) seq[gidx] = pre ^ 4'b0001;
        dpos = seq.size();
        for (int k = 0; k < 4; k++) begin
            for (int l = 0; l < 4; l++) w[l] = EXP_DELIM[15 - (4 * k + ((l - rot + 4) % 4))];
            seq.push_back(w);
        end
        for (int i = 0; i < 8; i++) seq.push_back(4'(i) ^ 4'h6);
        @(negedge clk);
        base = cyc + 1;
        sb.push_back('{kind: 0, val: sval, cyc: base + sidx});
        if (glitch) sb.push_back('{kind: 2, val: 0, cyc: base + gidx + 3});
        sb.push_back('{kind: 1, val: rot, cyc: base + dpos + 3});
        for (int i = 0; i < seq.size(); i++) begin
            lane = seq[i];
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 locked", int'(locked_o), 0);
        check("R1 settled", int'(settled_o), 0);
        check("R1 frame", int'(frame_start_o), 0);
        check("R1 error", int'(lock_err_o), 0);
        check("R1 rot", int'(rot_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 count after release", int'(settle_cycles_o), 0);
        mon_on = 1'b1;

        // R3 boundary: no noise, settle count 0; R9 preamble word 0xA
        drive_gap(GAP + 2);
        noise_q = {};
        run_burst(0, 1, 1'b0);
        check("R4 locked after frame", int'(locked_o), 1);

        // R4: a full gap drops lock
        drive_gap(GAP + 2);
        check("R4 lock dropped by gap", int'(locked_o), 0);

        // R3 noise, R6 glitch after settle, R9 preamble word 0x5
        noise_q = '{4'h3, 4'h3, 4'h5, 4'h9, 4'h9, 4'h9};
        run_burst(1, 1, 1'b1);

        // R2: short pause and more payload start nothing; R7 payload ignored
        drive_gap(GAP - 3);
        drive_payload(6);
        @(negedge clk);
        check("R2 short pause keeps lock", int'(locked_o), 1);
        check("R8 rot held", int'(rot_o), 1);

        // R3 boundary: quiet run one cycle short of stable_len
        drive_gap(GAP + 2);
        noise_q = '{4'h7, 4'h7, 4'h7, 4'h7, 4'h7, 4'h7, 4'h2};
        run_burst(2, 0, 1'b0);

        drive_gap(GAP + 2);
        noise_q = '{4'h1, 4'h2};
        run_burst(3, 1, 1'b0);

        drive_gap(GAP + 4);
        check("R8 rot held after gap", int'(rot_o), 3);
        check("R8 settle count held", int'(settle_cycles_o), 2);
        check("R5 R6 all expected events seen", sb.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired with %0d events pending", sb.size());
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule